// File: doc/BRIEF.md
# Timer Channel Pin Controller

This block owns the single IO pin of one timer channel. Software programs a mode register to make the pin a plain input, a push-pull output driven low or high, or an open-drain output that only ever pulls low. A single write to the two-bit direction field both enables the output and sets its level.

When the pin is an input, its level passes through a two-flop synchronizer. The synchronized level is reported in the status word. A programmable edge selector (rising, falling or both) latches a sticky event flag. Software clears the flag by writing a one to it. The flag, gated by an interrupt enable, drives a level interrupt. While the interrupt enable is set, the pin is forced to act as an input, whatever the direction field says.

Top module: `tpc_pin_top`

## Requirements
- R1: After reset, the pin output, output enable, status word and interrupt are all zero.
- R2: With mode bits 5:4 equal to 00 or 01, the output enable is low (input mode).
- R3: Mode bits 5:4 = 10 drive the pin low (enable 1, data 0). Mode bits 5:4 = 11 drive it high (enable 1, data 1). Each takes effect from one mode write.
- R4: With mode bit 9 set, the value 11 releases the pin (enable 0), while the value 10 still pulls it low.
- R5: While mode bit 8 (interrupt enable) is set, the output enable is low for every value of mode bits 5:4.
- R6: Status bit 8 shows the pin input as it was sampled two clock edges earlier (two-flop synchronizer).
- R7: Mode bits 17:16 select the edge type: 01 rising, 10 falling, 11 both. A qualifying change of the synchronized level sets status bit 0 on the next clock edge.
- R8: With mode bits 17:16 = 00, status bit 0 never sets.
- R9: Writing status with bit 0 = 1 clears the flag, and writing 0 leaves it alone. If a new event arrives in the same cycle as a clear, the flag stays set.
- R10: The interrupt is high exactly when status bit 0 is set and mode bit 8 is set. It stays high until the flag is cleared.
- R11: Status bits 15:9 and 7:1 always read zero. Mode write bits other than 17:16, 9, 8 and 5:4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 18 | Mode register write data |
| stat_we | input | 1 | Status write strobe (write-one-to-clear) |
| stat_wdata | input | 16 | Status write data |
| stat_rdata | output | 16 | Status word: bit 8 level, bit 0 event flag |
| pin_in | input | 1 | Pin input level (asynchronous) |
| pin_out | output | 1 | Pin output data |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the collisions between fields. Setting the interrupt enable on a driven-high pin must release it, and a design that ignored this would fight the external source. The open-drain high setting must release the pin rather than drive it. A clear that lands in the same cycle as a new edge must keep the flag; a design that gave the clear priority would lose that event. Rising-only and falling-only selections are exercised against the opposite edge to catch swapped codes. The edge-off setting is exercised with the pin toggling. Level reporting is compared cycle by cycle, which exposes a missing or extra synchronizer stage.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int MODE_W   = 18;
  localparam int STAT_W   = 16;
  localparam int DIR_LO   = 4;
  localparam int IEN_BIT  = 8;
  localparam int OD_BIT   = 9;
  localparam int EDGE_LO  = 16;
  localparam int LVL_BIT  = 8;
  localparam int FLAG_BIT = 0;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic [1:0] dir;
    logic       od;
    logic       ien;
    edge_sel_e  edge_sel;
  } pin_mode_t;
endpackage

// File: rtl/tpc_sync.sv
module tpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[LAST];
endmodule

// File: rtl/tpc_edge_cap.sv
module tpc_edge_cap
  import tpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  edge_sel_e edge_sel,
  input  logic      clr,
  output logic      flag
);
  logic prev_q;
  logic flag_q, flag_d;
  logic rise, fall, evt;

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    unique case (edge_sel)
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      EDGE_ANY:  evt = rise | fall;
      default:   evt = 1'b0;
    endcase
    if (evt)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == EDGE_OFF && !flag_q) |=> !flag_q); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag_q); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R10
  AST_RISE_IGNORES_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == EDGE_RISE && fall && !flag_q) |=> !flag_q); // R7
endmodule

// File: rtl/tpc_drive.sv
module tpc_drive
  import tpc_pkg::*;
(
  input  pin_mode_t mode,
  output logic      pin_out,
  output logic      pin_oe
);
  logic want_drive, want_high;

  always_comb begin
    want_drive = mode.dir[1] & ~mode.ien;
    want_high  = mode.dir[0];
    if (!want_drive) begin
      pin_oe  = 1'b0;
      pin_out = 1'b0;
    end else if (want_high && mode.od) begin
      pin_oe  = 1'b0;
      pin_out = 1'b0;
    end else begin
      pin_oe  = 1'b1;
      pin_out = want_high;
    end
  end
endmodule

// File: rtl/tpc_pin_top.sv
module tpc_pin_top
  import tpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [STAT_W-1:0] stat_rdata,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq
);
  pin_mode_t mode_q, mode_d;
  logic      lvl;
  logic      flag;
  logic      clr;

  always_comb begin
    mode_d = mode_q;
    if (mode_we) begin
      mode_d.dir      = mode_wdata[DIR_LO +: 2];
      mode_d.od       = mode_wdata[OD_BIT];
      mode_d.ien      = mode_wdata[IEN_BIT];
      mode_d.edge_sel = edge_sel_e'(mode_wdata[EDGE_LO +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '{dir: 2'b00, od: 1'b0, ien: 1'b0, edge_sel: EDGE_OFF};
    else        mode_q <= mode_d;
  end

  assign clr = stat_we & stat_wdata[FLAG_BIT];

  tpc_sync #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (lvl)
  );

  tpc_edge_cap u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lvl),
    .edge_sel(mode_q.edge_sel),
    .clr     (clr),
    .flag    (flag)
  );

  tpc_drive u_drv (
    .mode   (mode_q),
    .pin_out(pin_out),
    .pin_oe (pin_oe)
  );

  always_comb begin
    stat_rdata           = '0;
    stat_rdata[LVL_BIT]  = lvl;
    stat_rdata[FLAG_BIT] = flag;
  end

  assign irq = flag & mode_q.ien;

  AST_IRQ_MODE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.ien |-> !pin_oe); // R5
  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.od && mode_q.dir == 2'b11) |-> !pin_oe); // R4
  AST_IRQ_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr && !mode_we) |=> irq); // R10
endmodule

// File: tb/tpc_pin_top_tb.sv
module tpc_pin_top_tb;
  logic        clk;
  logic        rst_n;
  logic        mode_we;
  logic [17:0] mode_wdata;
  logic        stat_we;
  logic [15:0] stat_wdata;
  logic [15:0] stat_rdata;
  logic        pin_in;
  logic        pin_out;
  logic        pin_oe;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  tpc_pin_top u_dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference model
  bit m_samples[$];
  int m_dir, m_od, m_ien, m_edge;
  bit m_flag;

  function automatic void model_reset();
    m_samples = {1'b0, 1'b0, 1'b0};
    m_dir = 0; m_od = 0; m_ien = 0; m_edge = 0;
    m_flag = 1'b0;
  endfunction

  function automatic bit m_level();
    return m_samples[m_samples.size() - 2];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit now_l, old_l, hit;
      now_l = m_samples[m_samples.size() - 2];
      old_l = m_samples[m_samples.size() - 3];
      hit = ((m_edge == 1 || m_edge == 3) && now_l && !old_l) ||
            ((m_edge == 2 || m_edge == 3) && !now_l && old_l);
      if (hit) m_flag = 1'b1;
      else if (stat_we && stat_wdata[0]) m_flag = 1'b0;
      if (mode_we) begin
        m_dir  = int'(mode_wdata[5:4]);
        m_od   = int'(mode_wdata[9]);
        m_ien  = int'(mode_wdata[8]);
        m_edge = int'(mode_wdata[17:16]);
      end
      m_samples.push_back(pin_in);
      void'(m_samples.pop_front());
    end
  end

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", req, got, exp, cycles);
    end
  endtask

  task automatic compare_all();
    int e_oe, e_out;
    string oreq, freq;
    if (m_ien != 0)       begin e_oe = 0; e_out = 0; oreq = "R5"; end
    else if (m_dir < 2)   begin e_oe = 0; e_out = 0; oreq = "R2"; end
    else if (m_od != 0)   begin e_oe = (m_dir == 2) ? 1 : 0; e_out = 0; oreq = "R4"; end
    else                  begin e_oe = 1; e_out = m_dir - 2; oreq = "R3"; end
    freq = (m_edge == 0) ? "R8" : (stat_we ? "R9" : "R7");
    check(oreq, int'(pin_oe), e_oe);
    check(oreq, int'(pin_out), e_out);
    check("R6", int'(stat_rdata[8]), int'(m_level()));
    check(freq, int'(stat_rdata[0]), int'(m_flag));
    check("R11", int'({stat_rdata[15:9], stat_rdata[7:1]}), 0);
    check("R10", int'(irq), int'(m_flag && m_ien != 0));
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) compare_all();
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(int dir, int od, int ien, int edg, int junk);
    mode_wdata = '0;
    mode_wdata[5:4]   = 2'(dir);
    mode_wdata[9]     = 1'(od);
    mode_wdata[8]     = 1'(ien);
    mode_wdata[17:16] = 2'(edg);
    mode_wdata[3:0]   = 4'(junk);
    mode_wdata[15:10] = 6'(junk);
    mode_we = 1'b1;
    tick(1);
    mode_we = 1'b0;
    mode_wdata = '0;
    tick(1);
  endtask

  task automatic clear_flag(bit one);
    stat_we = 1'b1;
    stat_wdata = one ? 16'hFFFF : 16'hFFFE;
    tick(1);
    stat_we = 1'b0;
    stat_wdata = '0;
    tick(1);
  endtask

  initial begin
    model_reset();
    rst_n = 1'b0; mode_we = 1'b0; mode_wdata = '0;
    stat_we = 1'b0; stat_wdata = '0; pin_in = 1'b0;
    tick(3);
    // R1 reset state
    check("R1", int'(pin_oe), 0);
    check("R1", int'(pin_out), 0);
    check("R1", int'(stat_rdata), 0);
    check("R1", int'(irq), 0);
    rst_n = 1'b1;
    tick(2);
    // R2 R3 R4 R5 drive modes
    set_mode(2, 0, 0, 0, 0);
    set_mode(3, 0, 0, 0, 5);
    set_mode(1, 0, 0, 0, 0);
    set_mode(3, 1, 0, 0, 0);
    set_mode(2, 1, 0, 0, 0);
    set_mode(3, 0, 1, 0, 0);
    set_mode(2, 0, 1, 0, 0);
    set_mode(0, 0, 0, 0, 0);
    // R8 edge off with toggling pin
    for (int i = 0; i < 6; i++) begin pin_in = ~pin_in; tick(3); end
    pin_in = 1'b0; tick(4);
    // R7 rising only, enable masked first (R10)
    set_mode(0, 0, 0, 1, 0);
    pin_in = 1'b1; tick(5);
    set_mode(0, 0, 1, 1, 0);
    tick(3);
    clear_flag(1'b0);   // R9 writing zero keeps flag
    clear_flag(1'b1);   // R9 clear
    pin_in = 1'b0; tick(5); // falling ignored
    // R7 falling only
    set_mode(0, 0, 1, 2, 0);
    pin_in = 1'b1; tick(5);
    pin_in = 1'b0; tick(5);
    clear_flag(1'b1);
    // R7 both edges, with quick glitches
    set_mode(0, 0, 1, 3, 0);
    pin_in = 1'b1; tick(4);
    clear_flag(1'b1);
    pin_in = 1'b0; tick(4);
    // R9 clear held while edges arrive: set must win
    stat_we = 1'b1; stat_wdata = 16'h0001;
    for (int i = 0; i < 4; i++) begin pin_in = ~pin_in; tick(2); end
    stat_we = 1'b0; stat_wdata = '0;
    tick(4);
    pin_in = 1'b1; tick(1); pin_in = 1'b0; tick(6);
    clear_flag(1'b1);
    tick(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule